// File: doc/BRIEF.md
# Glitch-free clock source multiplexer

This block steers one of up to four unrelated, free-running input clocks onto a single clock output. A binary select input names the wanted source and may be changed at any moment, with every clock still toggling. The output never carries a shortened high or low phase. Every high phase it emits is a complete high phase of one source, and every low phase is at least as long as a source low phase.

A switch follows a break-before-make order. The outgoing source is withdrawn first, in its own clock domain. The incoming source is then taken in its own domain, and only once no other source is still active or on its way in. Each source owns a short enable chain clocked on its falling edges, so the gate that passes that clock only opens or closes while the clock is low.

A one-hot status word shows which source is driving the output right now. It reads all zeros in the gap between release and acquisition, so software polls it until the wanted bit appears. When the block is built for a single source there is nothing to switch: the clock passes straight through and the status word is fixed at 1.

Top module: `gcm_clock_mux`

## Requirements
- R1: While rst_n is low, status is all zero and clk_out is low. After release, with sel = 0, status becomes 0001 (bit i stands for source i) within SYNC_STAGES+1 periods of clk_src[0].
- R2: sel holds the binary index of the wanted source. Once a switch to index i is complete, status equals 1 << i and every high phase of clk_out lasts exactly one high phase of clk_src[i].
- R3: At no time does status have more than one bit set.
- R4: When switching between two different sources, status reads all zero for a nonzero interval between the old bit clearing and the new bit setting. A source that is no longer selected drops its enable within SYNC_STAGES of its own falling edges, and no two sources are ever active or acquiring at the same time.
- R5: Every high phase of clk_out equals a full high phase of one source, and every low phase of clk_out lasts at least the shortest source low phase.
- R6: A selected source whose rivals are all idle becomes enabled within SYNC_STAGES of its own falling edges. A whole switch completes within (SYNC_STAGES+1) periods of the old source plus (SYNC_STAGES+1) periods of the new one.
- R7: Driving sel to the index that is already active causes no gap: status keeps the same single bit set throughout.
- R8: If sel returns to the original source while a switch is under way, the block finishes the release and acquisition in progress and ends with the original source driving clk_out, with status equal to its bit and no runt phase.
- R9: With NUM_SRC = 1, status is constantly 1 and clk_out equals clk_src[0] at all times, reset included.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_src | input | NUM_SRC | Free-running source clocks, mutually asynchronous |
| rst_n | input | 1 | Asynchronous active-low reset of all enable chains |
| sel | input | SEL_W | Binary index of the wanted source; may change at any time |
| clk_out | output | 1 | Multiplexed clock output |
| status | output | NUM_SRC | One-hot indication of the source driving clk_out; all zero while switching |

## Verification
On every falling edge of every source, the assertions check three things: the status word has at most one bit set, at most one lane is active or acquiring, and each lane releases and acquires within its stage bound once its request has been stable long enough. Only the bench scenarios can show that the output waveform itself is clean. The bench measures every phase of clk_out, and it observes the all-zero gap, the no-gap case when the same source is reselected, and the result of reversing a switch halfway through. These are waveform and sequence properties across several unrelated clock domains, which per-domain clocked properties cannot express.

// File: rtl/gcm_pkg.sv
`timescale 1ns/1ps
package gcm_pkg;

  localparam int MAX_SRC = 4;

  typedef logic [MAX_SRC-1:0] src_vec_t;

  // True when the binary select value names lane idx.
  function automatic logic sel_hits(input int unsigned sel_v, input int unsigned idx);
    return sel_v == idx;
  endfunction

  // True when no lane other than idx is active or acquiring.
  function automatic logic others_idle(input src_vec_t busy_v, input int unsigned idx);
    src_vec_t m;
    m = busy_v;
    m[idx] = 1'b0;
    return m == '0;
  endfunction

  // Saturating increment used by the per-lane run counters.
  function automatic int unsigned sat_inc(input int unsigned v, input int unsigned lim);
    return (v >= lim) ? lim : v + 1;
  endfunction

endpackage

// File: rtl/gcm_sync_chain.sv
`timescale 1ns/1ps
module gcm_sync_chain #(
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              d,
  output logic [STAGES-1:0] taps,
  output logic              q
);

  logic [STAGES-1:0] r;

  // Falling-edge chain: the enable moves only while the clock is low.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) r <= '0;
    else        r <= {r[STAGES-2:0], d};
  end

  assign taps = r;
  assign q    = r[STAGES-1];

endmodule

// File: rtl/gcm_lane.sv
`timescale 1ns/1ps
module gcm_lane
  import gcm_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic want,
  input  logic others_idle_i,
  output logic busy,
  output logic en,
  output logic gated
);

  localparam int RUN_W = $clog2(SYNC_STAGES + 2);
  localparam int unsigned RUN_MAX = SYNC_STAGES;

  logic                   req;
  logic [SYNC_STAGES-1:0] taps;

  assign req = want & others_idle_i;

  gcm_sync_chain #(.STAGES(SYNC_STAGES)) u_chain (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (req),
    .taps (taps),
    .q    (en)
  );

  // Any set stage counts as busy so that rivals wait for the whole chain.
  assign busy  = |taps;
  assign gated = clk & en;

  // Run counters of consecutive edges with the request held off or on.
  logic [RUN_W-1:0] off_run;
  logic [RUN_W-1:0] on_run;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_run <= '0;
      on_run  <= '0;
    end else begin
      off_run <= want ? '0 : RUN_W'(sat_inc(int'(off_run), RUN_MAX));
      on_run  <= req  ? RUN_W'(sat_inc(int'(on_run), RUN_MAX)) : '0;
    end
  end

  AST_RELEASE_BOUND: assert property (@(negedge clk) disable iff (!rst_n)
    (off_run == RUN_W'(RUN_MAX)) |-> !en); // R4

  AST_ACQUIRE_BOUND: assert property (@(negedge clk) disable iff (!rst_n)
    (on_run == RUN_W'(RUN_MAX)) |-> en); // R6

endmodule

// File: rtl/gcm_clock_mux.sv
`timescale 1ns/1ps
module gcm_clock_mux
  import gcm_pkg::*;
#(
  parameter int NUM_SRC     = 4,
  parameter int SYNC_STAGES = 2,
  localparam int SEL_W      = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic [NUM_SRC-1:0] clk_src,
  input  logic               rst_n,
  input  logic [SEL_W-1:0]   sel,
  output logic               clk_out,
  output logic [NUM_SRC-1:0] status
);

  if (NUM_SRC == 1) begin : g_fixed
    // Nothing to switch: straight path, status fixed.
    logic unused_inputs;
    assign unused_inputs = ^{sel, rst_n};
    assign clk_out = clk_src[0];
    assign status  = 1'b1;
  end else begin : g_mux
    logic [NUM_SRC-1:0] want;
    logic [NUM_SRC-1:0] idle;
    logic [NUM_SRC-1:0] busy;
    logic [NUM_SRC-1:0] gated;
    src_vec_t           busy_pad;

    always_comb begin
      busy_pad = '0;
      busy_pad[NUM_SRC-1:0] = busy;
    end

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_lane
      assign want[i] = sel_hits(int'(unsigned'(sel)), i);
      assign idle[i] = others_idle(busy_pad, i);

      gcm_lane #(.SYNC_STAGES(SYNC_STAGES)) u_lane (
        .clk          (clk_src[i]),
        .rst_n        (rst_n),
        .want         (want[i]),
        .others_idle_i(idle[i]),
        .busy         (busy[i]),
        .en           (status[i]),
        .gated        (gated[i])
      );

      AST_STATUS_ONEHOT0: assert property (@(negedge clk_src[i]) disable iff (!rst_n)
        $onehot0(status)); // R3

      AST_BUSY_EXCLUSIVE: assert property (@(negedge clk_src[i]) disable iff (!rst_n)
        $onehot0(busy)); // R4
    end

    assign clk_out = |gated;
  end

endmodule

// File: tb/test_gcm_clock_mux.sv
`timescale 1ns/1ps
module test_gcm_clock_mux;

  logic [3:0] clks;
  logic       rst_n;
  logic [1:0] sel;
  logic       clk_out;
  logic [3:0] status;
  logic       clk_out_s;
  logic [0:0] status_s;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  realtime half [4] = '{5.0, 7.0, 11.0, 17.0};

  initial clks = '0;
  always #5  clks[0] = ~clks[0];   // 100 MHz
  always #7  clks[1] = ~clks[1];
  always #11 clks[2] = ~clks[2];
  always #17 clks[3] = ~clks[3];

  gcm_clock_mux #(.NUM_SRC(4), .SYNC_STAGES(2)) i_gcm_clock_mux (
    .clk_src(clks), .rst_n(rst_n), .sel(sel), .clk_out(clk_out), .status(status)
  );

  gcm_clock_mux #(.NUM_SRC(1), .SYNC_STAGES(2)) i_gcm_clock_mux_single (
    .clk_src(clks[0:0]), .rst_n(rst_n), .sel(1'b0), .clk_out(clk_out_s), .status(status_s)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit legal_high(input realtime w);
    for (int k = 0; k < 4; k++)
      if (w > half[k] - 0.01 && w < half[k] + 0.01) return 1;
    return 0;
  endfunction

  // R5: phase-width monitor on clk_out.
  bit      mon_on = 0;
  bit      mon_armed = 0;
  realtime t_last;
  always @(clk_out) begin
    if (mon_on) begin
      if (mon_armed) begin
        if (clk_out == 1'b0)
          chk(legal_high($realtime - t_last), "R5", "high phase width (ps)",
              longint'(($realtime - t_last) * 1000), 5000);
        else
          chk(($realtime - t_last) > 4.99, "R5", "low phase width (ps)",
              longint'(($realtime - t_last) * 1000), 5000);
      end
      mon_armed = 1;
      t_last = $realtime;
    end
  end

  task automatic wait_for(input logic [3:0] exp, input realtime limit,
                          output bit ok, output bit saw_zero, output bit saw_multi);
    realtime t0;
    t0 = $realtime;
    ok = 0; saw_zero = 0; saw_multi = 0;
    while ($realtime - t0 < limit) begin
      #1;
      if (status == 4'b0) saw_zero = 1;
      if ($countones(status) > 1) saw_multi = 1;
      if (status == exp) begin
        ok = 1;
        break;
      end
    end
  endtask

  task automatic follow(input int t, input string req);
    realtime t1;
    @(posedge clk_out);
    t1 = $realtime;
    @(negedge clk_out);
    chk(($realtime - t1) > half[t] - 0.01 && ($realtime - t1) < half[t] + 0.01,
        req, "high phase after switch (ps)", longint'(($realtime - t1) * 1000),
        longint'(half[t] * 1000));
    #0.3;
  endtask

  function automatic realtime bound(input int f, input int t);
    return 6.0 * (half[f] + half[t]) + 10.0;
  endfunction

  task automatic go_to(input int t);
    bit ok, z, m;
    sel = 2'(t);
    wait_for(4'(1 << t), 400.0, ok, z, m);
    chk(ok, "R2", "status when settling", status, 1 << t);
  endtask

  initial begin
    bit ok, z, m;
    rst_n = 0;
    sel   = 2'd0;
    #20.3;
    // R1: reset state
    chk(status == 4'b0, "R1", "status in reset", status, 0);
    chk(clk_out == 1'b0, "R1", "clk_out in reset", clk_out, 0);
    // R9: single-source variant, during reset
    chk(status_s == 1'b1, "R9", "fixed status in reset", status_s, 1);
    rst_n = 1;
    mon_on = 1;
    wait_for(4'b0001, 3.0 * 2.0 * half[0] + 1.0, ok, z, m);
    chk(ok, "R1", "status after reset", status, 1);
    follow(0, "R1");

    // Full sweep of every source pair.
    for (int f = 0; f < 4; f++) begin
      for (int t = 0; t < 4; t++) begin
        go_to(f);
        #0.3;
        if (f != t) begin
          sel = 2'(t);
          wait_for(4'(1 << t), bound(f, t), ok, z, m);
          chk(ok, "R6", $sformatf("switch %0d->%0d within bound", f, t), status, 1 << t);
          chk(ok, "R2", $sformatf("status after %0d->%0d", f, t), status, 1 << t);
          chk(z, "R4", $sformatf("zero gap seen %0d->%0d", f, t), z, 1);
          chk(!m, "R3", $sformatf("multiple bits %0d->%0d", f, t), m, 0);
          follow(t, "R2");
        end else begin
          sel = 2'(t);
          z = 0; m = 0; ok = 1;
          for (int k = 0; k < 80; k++) begin
            #1;
            if (status != 4'(1 << t)) ok = 0;
          end
          chk(ok, "R7", $sformatf("reselect %0d keeps status", t), status, 1 << t);
          follow(t, "R7");
        end
      end
    end

    // R8: reverse a switch early and in the middle of its gap.
    for (int f = 0; f < 4; f++) begin
      int t;
      t = (f + 1) % 4;
      go_to(f);
      #0.3;
      sel = 2'(t);
      #2;
      sel = 2'(f);
      wait_for(4'(1 << f), 2.0 * bound(f, t), ok, z, m);
      chk(ok, "R8", $sformatf("early reversal back to %0d", f), status, 1 << f);
      chk(!m, "R3", "multiple bits during early reversal", m, 0);
      follow(f, "R8");

      t = (f + 3) % 4;
      sel = 2'(t);
      ok = 0;
      for (int k = 0; k < 200; k++) begin
        #1;
        if (status == 4'b0) begin
          ok = 1;
          break;
        end
      end
      chk(ok, "R4", "gap reached before reversal", status, 0);
      sel = 2'(f);
      wait_for(4'(1 << f), 2.0 * bound(f, t), ok, z, m);
      chk(ok, "R8", $sformatf("mid-gap reversal back to %0d", f), status, 1 << f);
      chk(!m, "R3", "multiple bits during mid-gap reversal", m, 0);
      follow(f, "R8");
    end

    // R9: single-source variant follows its clock after reset.
    ok = 1;
    for (int k = 0; k < 40; k++) begin
      #1;
      if (clk_out_s != clks[0] || status_s != 1'b1) ok = 0;
    end
    chk(ok, "R9", "single-source passthrough", clk_out_s, clks[0]);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R6 watchdog: got 0 expected 1 (run completion)");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule